// File: doc/BRIEF.md
# Conditional Program Flow Unit

This block keeps the program counter of a small 16-bit sequencer and carries out its conditional control transfers. On each accepted instruction it decodes four kinds of transfer: jump, call, return, and return from exception. Each carries a 4-bit condition field that is tested against the zero and carry flag inputs. Any other instruction word simply moves the program counter on by one.

Jumps and calls are two words long. The address word is presented on `ext_word` in the same cycle as the opcode word. Return addresses live on an 8-entry call stack. Saved status values live on a separate 8-entry data stack, which the exception entry path fills through `exc_save`. A taken return from exception restores the status output from the data stack and the program counter from the call stack in one step, popping both.

The instruction input is a valid/ready stream that never applies back-pressure. `ins_ready` is held high, so every cycle with `ins_valid` high consumes one instruction. A cycle with `ins_valid` low leaves the program counter untouched.

Top module: `flow_ctl_unit`

## Requirements
- R1: Reset sets `pc` and `sr_out` to zero and empties both stacks, so a taken return straight after reset underflows.
- R2: `ins_ready` is always 1. In a cycle with `ins_valid` low, `pc` keeps its value.
- R3: The condition field is the low four bits of the word. 0000 is always, 0001 is zero set, 0010 is zero clear, 0011 is carry set and 0100 is carry clear. Every other code never holds.
- R4: A jump (upper twelve bits 0x029) loads `pc` from `ext_word` when its condition holds. Otherwise it adds 2 to `pc`.
- R5: A call (upper bits 0x02B) that is taken pushes `pc`+2 onto the call stack and loads `pc` from `ext_word`. When the condition fails, it adds 2 to `pc`.
- R6: A return (upper bits 0x02D) that is taken loads `pc` from the top of the call stack and pops it. When the condition fails, it adds 1 to `pc`.
- R7: A return from exception (upper bits 0x02F) that is taken loads `sr_out` from the top of the data stack and `pc` from the top of the call stack, and pops both in the same cycle. When the condition fails, it adds 1 to `pc` and leaves `sr_out` unchanged.
- R8: Any other accepted word adds 1 to `pc`.
- R9: A push to a full stack (8 entries) raises that stack's overflow output for one cycle and leaves the stack contents unchanged. A call that overflows still jumps.
- R10: A pop from an empty stack raises that stack's underflow output for one cycle. A return that finds the call stack empty adds 1 to `pc`. A restore that finds the data stack empty leaves `sr_out` unchanged.
- R11: `exc_save` pushes `exc_sr` onto the data stack. When it coincides with a taken return from exception on a non-empty data stack, `sr_out` takes the old top and `exc_sr` replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word is present |
| ins_ready | output | 1 | Always high; the unit accepts one word per cycle |
| ins_word | input | 16 | Opcode word |
| ext_word | input | 16 | Address word of a two-word instruction |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| exc_save | input | 1 | Push `exc_sr` onto the data stack |
| exc_sr | input | 16 | Status value to save |
| pc | output | 16 | Program counter |
| sr_out | output | 16 | Restored status register |
| cs_ovf | output | 1 | Call stack overflow pulse |
| cs_unf | output | 1 | Call stack underflow pulse |
| ds_ovf | output | 1 | Data stack overflow pulse |
| ds_unf | output | 1 | Data stack underflow pulse |

## Verification
The hardest situation to reach from the ports is a push onto a full call stack. Reaching it takes eight nested taken calls without any return in between. The test then has to show that the ninth return address was dropped and not written over the top entry. The bench chains nine calls to known targets, then unwinds with returns and checks that the first return lands on the address pushed by the eighth call. A second sequence fires `exc_save` in the same cycle as a taken restore, to reach the simultaneous push and pop on the data stack.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [2:0] {
    OP_OTHER, OP_JUMP, OP_CALL, OP_RET, OP_RTX
  } flow_op_e;

  function automatic logic cond_met(input logic [3:0] code, input logic z, input logic c);
    case (code)
      4'd0:    cond_met = 1'b1;
      4'd1:    cond_met = z;
      4'd2:    cond_met = !z;
      4'd3:    cond_met = c;
      4'd4:    cond_met = !c;
      default: cond_met = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
(
  input  logic [15:0] word,
  output flow_op_e    op,
  output logic [3:0]  code
);
  always_comb begin
    code = word[3:0];
    case (word[15:4])
      12'h029: op = OP_JUMP;
      12'h02B: op = OP_CALL;
      12'h02D: op = OP_RET;
      12'h02F: op = OP_RTX;
      default: op = OP_OTHER;
    endcase
  end
endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] top_idx, wr_idx;
  logic          full, do_pop, do_push;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign top_idx = AW'(cnt - CW'(1));
  assign wr_idx  = AW'(cnt);
  assign top     = mem[top_idx];
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[do_pop ? top_idx : wr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
      ovf <= push && !do_push;
      unf <= pop && !do_pop;
    end
  end

  a_r9_full_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == CW'(DEPTH)) && ovf);
  a_r10_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt == '0) && unf);
  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
  import flow_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ins_valid,
  output logic         ins_ready,
  input  logic [15:0]  ins_word,
  input  logic [W-1:0] ext_word,
  input  logic         flag_z,
  input  logic         flag_c,
  input  logic         exc_save,
  input  logic [W-1:0] exc_sr,
  output logic [W-1:0] pc,
  output logic [W-1:0] sr_out,
  output logic         cs_ovf,
  output logic         cs_unf,
  output logic         ds_ovf,
  output logic         ds_unf
);
  flow_op_e     op;
  logic [3:0]   code;
  logic         taken, cs_push, cs_pop, ds_pop;
  logic [W-1:0] cs_top, ds_top, pc_next;
  logic         cs_empty, ds_empty;

  assign ins_ready = 1'b1;

  flow_decode u_dec (.word(ins_word), .op(op), .code(code));

  assign taken   = ins_valid && cond_met(code, flag_z, flag_c);
  assign cs_push = taken && (op == OP_CALL);
  assign cs_pop  = taken && ((op == OP_RET) || (op == OP_RTX));
  assign ds_pop  = taken && (op == OP_RTX);

  flow_stack #(.W(W), .DEPTH(DEPTH)) u_cstk (
    .clk(clk), .rst_n(rst_n), .push(cs_push), .din(pc + W'(2)),
    .pop(cs_pop), .top(cs_top), .empty(cs_empty), .ovf(cs_ovf), .unf(cs_unf));

  flow_stack #(.W(W), .DEPTH(DEPTH)) u_dstk (
    .clk(clk), .rst_n(rst_n), .push(exc_save), .din(exc_sr),
    .pop(ds_pop), .top(ds_top), .empty(ds_empty), .ovf(ds_ovf), .unf(ds_unf));

  always_comb begin
    pc_next = pc;
    if (ins_valid) begin
      case (op)
        OP_JUMP, OP_CALL: pc_next = taken ? ext_word : pc + W'(2);
        OP_RET, OP_RTX:   pc_next = (taken && !cs_empty) ? cs_top : pc + W'(1);
        default:          pc_next = pc + W'(1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      sr_out <= '0;
    end else begin
      pc <= pc_next;
      if (ds_pop && !ds_empty) sr_out <= ds_top;
    end
  end

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(pc));
  a_r4_jump_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && op == OP_JUMP && !taken) |=> pc == $past(pc) + W'(2));
  a_r7_sr_only_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_pop |=> $stable(sr_out));
  a_r5_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    cs_push |=> pc == $past(ext_word));
endmodule

// File: tb/flow_ctl_unit_test.sv
module flow_ctl_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, flag_z = 1'b0, flag_c = 1'b0, exc_save = 1'b0;
  logic [15:0] ins_word = '0, ext_word = '0, exc_sr = '0;
  logic ins_ready, cs_ovf, cs_unf, ds_ovf, ds_unf;
  logic [15:0] pc, sr_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flow_ctl_unit uut (.*);

  // {ins_word, ext_word, z, c, expected pc}
  localparam logic [49:0] VEC [10] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0001},  // R8 plain word
    {16'h0290, 16'h0040, 1'b0, 1'b0, 16'h0040},  // R4 always jump
    {16'h0291, 16'h0999, 1'b0, 1'b0, 16'h0042},  // R3 zero set fails
    {16'h0292, 16'h0100, 1'b0, 1'b0, 16'h0100},  // R3 zero clear holds
    {16'h02B3, 16'h0200, 1'b0, 1'b1, 16'h0200},  // R5 call taken
    {16'h02B4, 16'h0300, 1'b0, 1'b1, 16'h0202},  // R5 call skipped
    {16'h02D5, 16'h0000, 1'b1, 1'b1, 16'h0203},  // R6 never code
    {16'h02D0, 16'h0000, 1'b0, 1'b0, 16'h0102},  // R6 return
    {16'h0294, 16'h0010, 1'b0, 1'b0, 16'h0010},  // R3 carry clear
    {16'h029F, 16'h0777, 1'b1, 1'b1, 16'h0012}   // R3 code 15 never
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] w, input logic [15:0] x,
                      input logic z, input logic c, input logic sv, input logic [15:0] sd);
    @(negedge clk);
    ins_valid = v; ins_word = w; ext_word = x; flag_z = z; flag_c = c;
    exc_save = sv; exc_sr = sd;
    @(negedge clk);
    ins_valid = 1'b0; exc_save = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 pc", pc, 16'h0);
    chk("R1 sr", sr_out, 16'h0);
    chk("R2 ready", {15'd0, ins_ready}, 16'h1);

    for (int i = 0; i < 10; i++) begin
      step(1'b1, VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16], 1'b0, 16'h0);
      chk($sformatf("R3-table step %0d pc", i), pc, VEC[i][15:0]);
      chk("R9 no ovf in table", {15'd0, cs_ovf}, 16'h0);
    end

    step(1'b0, 16'h0290, 16'h0abc, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R2 idle hold", pc, 16'h0012);

    // R1 / R10: empty stack after reset
    do_reset();
    step(1'b1, 16'h02D0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R10 ret empty pc", pc, 16'h0001);
    chk("R1 call stack empty", {15'd0, cs_unf}, 16'h1);

    // R7 restore
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 16'hA5A5);
    chk("R11 save no pc move", pc, 16'h0001);
    step(1'b1, 16'h02B0, 16'h0050, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R5 call pc", pc, 16'h0050);
    step(1'b1, 16'h02F1, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R7 skipped pc", pc, 16'h0051);
    chk("R7 skipped sr", sr_out, 16'h0000);
    step(1'b1, 16'h02F0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R7 taken pc", pc, 16'h0003);
    chk("R7 taken sr", sr_out, 16'hA5A5);
    step(1'b1, 16'h02F0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R10 rtx empty pc", pc, 16'h0004);
    chk("R10 rtx empty sr", sr_out, 16'hA5A5);
    chk("R10 cs unf", {15'd0, cs_unf}, 16'h1);
    chk("R10 ds unf", {15'd0, ds_unf}, 16'h1);

    // R11 simultaneous save and restore
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 16'h1111);
    step(1'b1, 16'h02B0, 16'h0060, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b1, 16'h02B0, 16'h0070, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b1, 16'h02F0, 16'h0, 1'b0, 1'b0, 1'b1, 16'h2222);
    chk("R11 pc", pc, 16'h0062);
    chk("R11 old top out", sr_out, 16'h1111);
    step(1'b1, 16'h02F0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R11 new top", sr_out, 16'h2222);
    chk("R11 pc2", pc, 16'h0006);
    chk("R11 no unf", {15'd0, ds_unf}, 16'h0);

    // R9 call stack overflow
    do_reset();
    for (int i = 0; i < 9; i++) begin
      step(1'b1, 16'h02B0, 16'((i + 1) * 16), 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R9 call pc", pc, 16'((i + 1) * 16));
      chk("R9 ovf flag", {15'd0, cs_ovf}, (i == 8) ? 16'h1 : 16'h0);
    end
    for (int i = 7; i >= 0; i--) begin
      step(1'b1, 16'h02D0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R9 unwind pc", pc, 16'(i * 16 + 2));
    end
    step(1'b1, 16'h02D0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R10 after unwind", {15'd0, cs_unf}, 16'h1);

    // R9 data stack overflow
    for (int i = 0; i < 9; i++) begin
      step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 16'(i));
      chk("R9 ds ovf", {15'd0, ds_ovf}, (i == 8) ? 16'h1 : 16'h0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule